// File: doc/BRIEF.md
# Return Address Stack

This block keeps the return addresses of a small processor core in a stack of fixed depth. Software cannot read or write it. A push request stores the 11-bit program counter. The core raises a push for a subroutine call and for an interrupt acknowledgement. A pop request comes from a return or a return-from-interrupt instruction. It moves the most recent stored address onto a registered output, and the core loads that value back into its program counter.

The storage is a circular buffer. A wrapping slot index and a separate occupancy count track it. When the buffer already holds four addresses, a further push overwrites the oldest slot, so the newest four addresses remain. The `full` output lets the interrupt logic hold off an acknowledgement until a return has freed a level. The `empty` output reports that no address is held. A pop on an empty stack gives back the slot that was read last and changes no state. A push and a pop in the same cycle is an error: the pop is carried out, the push is dropped, and `conflict` pulses for one cycle.

Top module: `return_stack`

## Requirements
- R1: After a synchronous active-low reset, `empty` is 1, `full` is 0, `pop_addr` is 0 and `conflict` is 0. Every stored slot is cleared to 0.
- R2: Pops return pushed addresses in last-in, first-out order. `pop_addr` shows the popped value in the cycle after the pop request.
- R3: `full` is 1 exactly when 4 addresses are held, and `empty` is 1 exactly when none are held. The two are never 1 together.
- R4: A push while full overwrites the oldest entry and the stack stays full. After five pushes A..E, four pops return E, D, C, B, and the stack is then empty.
- R5: A pop while empty leaves the stack empty and loads `pop_addr` with the slot read by the most recent pop. After reset that slot holds 0.
- R6: A cycle with both push and pop requests performs only the pop. The push address is not stored, and `conflict` is 1 in the following cycle only.
- R7: `pop_addr` holds its value in any cycle without a pop request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push_req | input | 1 | Store `push_addr` (call or interrupt acknowledge) |
| push_addr | input | 11 | Program counter value to store |
| pop_req | input | 1 | Pop the newest entry (return instructions) |
| pop_addr | output | 11 | Registered popped return address |
| full | output | 1 | 4 entries held |
| empty | output | 1 | No entry held |
| conflict | output | 1 | One-cycle pulse after a simultaneous push and pop |

## Verification
The bench builds the block with its default parameters: a depth of 4 and an address width of 11 bits. With a depth of only four, a short sequence can fill the stack, overwrite it and drain it again. The index therefore wraps past slot 3 and back in both directions. The 11-bit width lets the bench use the all-ones address 0x7FF to check that no data bit is lost.

// File: rtl/rstk_pkg.sv
// Shared definitions for the return address stack.
// Assumes: requests are single-cycle strobes sampled on the rising clock edge.
package rstk_pkg;

    typedef enum logic [1:0] {
        STK_IDLE  = 2'd0,
        STK_PUSH  = 2'd1,
        STK_POP   = 2'd2,
        STK_CLASH = 2'd3
    } stk_op_e;

    // Map the raw request strobes to one operation; a clash still pops.
    function automatic stk_op_e stk_decode(input logic push, input logic pop);
        if (push && pop) return STK_CLASH;
        if (pop)         return STK_POP;
        if (push)        return STK_PUSH;
        return STK_IDLE;
    endfunction

endpackage

// File: rtl/rstk_index.sv
// Slot index and occupancy count of the circular return stack.
// Assumes: DEPTH is a power of two so that the index wraps naturally.
module rstk_index
    import rstk_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  stk_op_e       op,
    output logic [IW-1:0] wr_slot,
    output logic          wr_en,
    output logic [IW-1:0] rd_slot,
    output logic          rd_en,
    output logic          is_full,
    output logic          is_empty,
    output logic          clash_q
);

    logic [IW-1:0] idx_q;
    logic [CW-1:0] cnt_q;
    logic          do_pop;

    // Derive status and slot selection from the current index and count.
    always_comb begin
        is_full  = (cnt_q == CW'(DEPTH));
        is_empty = (cnt_q == '0);
        do_pop   = (op == STK_POP) || (op == STK_CLASH);
        wr_en    = (op == STK_PUSH);
        wr_slot  = idx_q;
        rd_en    = do_pop;
        rd_slot  = is_empty ? idx_q : idx_q - 1'b1;
    end

    // Advance the index and occupancy count for each operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            cnt_q <= '0;
        end else if (wr_en) begin
            idx_q <= idx_q + 1'b1;
            if (!is_full) cnt_q <= cnt_q + 1'b1;
        end else if (do_pop && !is_empty) begin
            idx_q <= idx_q - 1'b1;
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Flag a simultaneous push and pop for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) clash_q <= 1'b0;
        else        clash_q <= (op == STK_CLASH);
    end

endmodule

// File: rtl/rstk_store.sv
// Register file holding the stacked return addresses.
// Assumes: at most one write per cycle; the read is combinational.
module rstk_store #(
    parameter int DEPTH = 4,
    parameter int AW    = 11,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_slot,
    input  logic [AW-1:0] wr_data,
    input  logic [IW-1:0] rd_slot,
    output logic [AW-1:0] rd_data
);

    logic [AW-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Hold one return address; load it when this slot is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (wr_en && (wr_slot == IW'(g)))
                slot_q[g] <= wr_data;
        end
    end

    // Select the slot to be popped.
    always_comb rd_data = slot_q[rd_slot];

endmodule

// File: rtl/return_stack.sv
// Return address stack: circular buffer that keeps the newest DEPTH entries.
// Assumes: the core stops issuing interrupt pushes while full is high.
module return_stack
    import rstk_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = 11,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic [AW-1:0] push_addr,
    input  logic          pop_req,
    output logic [AW-1:0] pop_addr,
    output logic          full,
    output logic          empty,
    output logic          conflict
);

    stk_op_e       op;
    logic [IW-1:0] wr_slot, rd_slot;
    logic          wr_en, rd_en;
    logic [AW-1:0] rd_data;

    // Classify the request strobes of this cycle.
    always_comb op = stk_decode(push_req, pop_req);

    rstk_index #(.DEPTH(DEPTH)) u_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .wr_slot  (wr_slot),
        .wr_en    (wr_en),
        .rd_slot  (rd_slot),
        .rd_en    (rd_en),
        .is_full  (full),
        .is_empty (empty),
        .clash_q  (conflict)
    );

    rstk_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_slot (wr_slot),
        .wr_data (push_addr),
        .rd_slot (rd_slot),
        .rd_data (rd_data)
    );

    // Register the popped address; keep it while no pop occurs.
    always_ff @(posedge clk) begin
        if (!rst_n)     pop_addr <= '0;
        else if (rd_en) pop_addr <= rd_data;
    end

endmodule

// File: rtl/return_stack_chk.sv
// Port-level properties of the return address stack, attached by bind.
module return_stack_chk #(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_req,
    input logic          pop_req,
    input logic [AW-1:0] pop_addr,
    input logic          full,
    input logic          empty,
    input logic          conflict
);

    // R3
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R2
    push_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !pop_req) |=> !empty);

    // R4
    overwrite_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_req && !pop_req) |=> full);

    // R5
    empty_pop_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop_req) |=> empty);

    // R6
    clash_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req) |=> conflict);

    // R6
    clash_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_req && pop_req) |=> !conflict);

    // R7
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_req |=> $stable(pop_addr));

endmodule

bind return_stack return_stack_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (push_req),
    .pop_req  (pop_req),
    .pop_addr (pop_addr),
    .full     (full),
    .empty    (empty),
    .conflict (conflict)
);

// File: tb/return_stack_tb.sv
module return_stack_tb;

    localparam int AW = 11;
    localparam int NV = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_req = 1'b0;
    logic          pop_req = 1'b0;
    logic [AW-1:0] push_addr = '0;
    logic [AW-1:0] pop_addr;
    logic          full, empty, conflict;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    return_stack u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_req),
        .push_addr (push_addr),
        .pop_req   (pop_req),
        .pop_addr  (pop_addr),
        .full      (full),
        .empty     (empty),
        .conflict  (conflict)
    );

    // {push, pop, push_addr, exp pop_addr, exp full, exp empty, exp conflict}
    localparam logic [26:0] VEC [NV] = '{
        {1'b1, 1'b0, 11'h101, 11'h000, 1'b0, 1'b0, 1'b0},   // R2 push A
        {1'b1, 1'b0, 11'h202, 11'h000, 1'b0, 1'b0, 1'b0},   // R2 push B
        {1'b1, 1'b0, 11'h303, 11'h000, 1'b0, 1'b0, 1'b0},   // push C
        {1'b1, 1'b0, 11'h404, 11'h000, 1'b1, 1'b0, 1'b0},   // R3 fourth push -> full
        {1'b1, 1'b0, 11'h505, 11'h000, 1'b1, 1'b0, 1'b0},   // R4 overwrite oldest
        {1'b0, 1'b1, 11'h000, 11'h505, 1'b0, 1'b0, 1'b0},   // R4 pop E
        {1'b0, 1'b1, 11'h000, 11'h404, 1'b0, 1'b0, 1'b0},   // pop D
        {1'b0, 1'b1, 11'h000, 11'h303, 1'b0, 1'b0, 1'b0},   // pop C
        {1'b0, 1'b1, 11'h000, 11'h202, 1'b0, 1'b1, 1'b0},   // R4 pop B, empty
        {1'b0, 1'b1, 11'h000, 11'h202, 1'b0, 1'b1, 1'b0},   // R5 empty pop
        {1'b1, 1'b1, 11'h0AA, 11'h202, 1'b0, 1'b1, 1'b1},   // R6 clash on empty
        {1'b0, 1'b0, 11'h000, 11'h202, 1'b0, 1'b1, 1'b0},   // R7 idle hold
        {1'b1, 1'b0, 11'h7FF, 11'h202, 1'b0, 1'b0, 1'b0},   // push all-ones
        {1'b1, 1'b0, 11'h011, 11'h202, 1'b0, 1'b0, 1'b0},   // push
        {1'b1, 1'b1, 11'h3C3, 11'h011, 1'b0, 1'b0, 1'b1},   // R6 clash pops
        {1'b0, 1'b1, 11'h000, 11'h7FF, 1'b0, 1'b1, 1'b0},   // R2 pop all-ones
        {1'b0, 1'b0, 11'h000, 11'h7FF, 1'b0, 1'b1, 1'b0}    // R7 idle hold
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic ps, input logic pp, input logic [AW-1:0] a);
        @(negedge clk);
        push_req  = ps;
        pop_req   = pp;
        push_addr = a;
        @(posedge clk);
        #1;
    endtask

    task automatic check_outs(input string req, input logic [AW-1:0] pa,
                              input logic f, input logic e, input logic c);
        check({req, " pop_addr"}, int'(pop_addr), int'(pa));
        check({req, " full"},     int'(full),     int'(f));
        check({req, " empty"},    int'(empty),    int'(e));
        check({req, " conflict"}, int'(conflict), int'(c));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_outs("R1 reset", '0, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][26], VEC[i][25], VEC[i][24:14]);
            check_outs($sformatf("R2-vec%0d", i), VEC[i][13:3],
                       VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // R1: reset mid-operation clears everything
        step(1'b1, 1'b0, 11'h155);
        step(1'b1, 1'b0, 11'h2AA);
        @(negedge clk);
        push_req = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check_outs("R1 midrun reset", '0, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R5: empty pop right after reset returns the cleared slot
        step(1'b0, 1'b1, '0);
        check_outs("R5 pop after reset", '0, 1'b0, 1'b1, 1'b0);

        // R3: count up to full one push at a time
        for (int i = 0; i < 4; i++) begin
            step(1'b1, 1'b0, AW'(11'h040 + i));
            check("R3 full flag", int'(full), int'(i == 3));
            check("R3 empty flag", int'(empty), 0);
        end
        // R6: clash on full pops newest and does not store push
        step(1'b1, 1'b1, 11'h666);
        check_outs("R6 clash on full", 11'h043, 1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b1, '0);
        check_outs("R6 push dropped", 11'h042, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, '0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule